// File: doc/BRIEF.md
# Broadcast Shadow Bank with Two-Step Commit

This block is a register slave that models how a bandwidth limit setting travels from a configuration write to the value that hardware acts on. Software writes a minimum or maximum bandwidth value for one partition. That single write fans out to the partition's entry in twelve shadow slices. Each slice applies the update after its own fixed latency, so for a few cycles after a write the slices disagree.

The shadow entries can be read back as 64-bit words, with the maximum in the upper half and the minimum in the lower half. They cannot be written. The values that leave the block sit in a final rank of active registers, one minimum and one maximum per partition. These hold their reset value of zero, which means no bandwidth is provisioned, until software makes two writes to the spare locations. The second of those writes copies every partition's entry from the slowest slice into the active rank.

Software is expected to poll the shadow copies until all twelve agree before it commits. If it commits too early, the active rank picks up stale values.

Top module: `sbank_top`

## Requirements
- R1: After reset, every active minimum and maximum is zero, every shadow entry reads as zero, and `rd_valid` is low.
- R2: A write to 0x000000 + 8·p stores `wr_data[31:0]` as the minimum of partition p. A write to 0x000100 + 8·p stores `wr_data[63:32]` as the maximum. Either write reaches partition p in all twelve slices and leaves the other half of the entry unchanged.
- R3: A write accepted on clock edge k takes effect in slice s on edge k + LAT_BASE + s·LAT_STEP. With the defaults that is k + 1 + s, so slice 0 is the fastest and slice 11 the slowest. A read sampled on or before that edge returns the old entry.
- R4: Shadow entry (s, p) is read at 0x360048 + s·0x10000 + p·8 and returns {maximum, minimum}. Writes to these addresses do not change any entry.
- R5: The active outputs change only on a commit. A spare write made while the bank is not armed only arms it.
- R6: A spare write (0x1B0000 or 0x1C0000, in any mix) made while armed loads every partition's active minimum and maximum from the slowest slice on that edge, and disarms the bank.
- R7: A commit made before the slowest slice has applied a pending write loads the old values for that partition.
- R8: A configuration write whose partition index is 16 or more is dropped and changes no slice.
- R9: `rd_valid` goes high on the edge after `rd_en` is sampled, and `rd_data` is updated on that same edge. Reads of unmapped, misaligned, configuration or spare addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 24 | Byte address of the write |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Byte address of the read |
| rd_data | output | 64 | Read data, registered |
| rd_valid | output | 1 | High for one cycle when rd_data carries a read result |
| act_min | output | 512 | Active minimum per partition, 32 bits each, partition p at bits 32·p + 31 down to 32·p |
| act_max | output | 512 | Active maximum per partition, same packing |

## Verification
The assertions assume that `wr_en` and `rd_en` are never unknown once reset is released. They also assume that a spare write never lands on the same edge as the slowest slice applying an update, because in that case the commit takes the value as it stood before that edge.

The stimulus changes inputs only on falling edges. It waits more than twelve cycles after each configuration write whenever it needs settled values. It places its early commits and early reads on edges counted from the write, so that every stale value it expects is fixed by the latency rule and does not depend on scheduling.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int unsigned VAL_W       = 32;
  localparam int unsigned REG_W       = 2 * VAL_W;
  localparam int unsigned ADDR_W      = 24;
  localparam int unsigned PID_FIELD_W = 5;

  localparam logic [ADDR_W-1:0] SHADOW_BASE = 24'h360048;
  localparam logic [ADDR_W-1:0] SPARE_A     = 24'h1B0000;
  localparam logic [ADDR_W-1:0] SPARE_B     = 24'h1C0000;

  // One broadcast update travelling down a slice's latency line
  typedef struct packed {
    logic                   vld;
    logic                   hi;   // 1: maximum half, 0: minimum half
    logic [PID_FIELD_W-1:0] pid;
    logic [VAL_W-1:0]       val;
  } bcast_t;
endpackage

// File: rtl/sbank_delay.sv
module sbank_delay
  import sbank_pkg::*;
#(
  parameter int unsigned DEPTH = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  bcast_t d_in,
  output bcast_t d_out
);
  bcast_t stage_q [DEPTH];
  bcast_t stage_d [DEPTH];

  always_comb begin
    stage_d[0] = d_in;
    for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign d_out = stage_q[DEPTH-1];
endmodule

// File: rtl/sbank_slice.sv
module sbank_slice
  import sbank_pkg::*;
#(
  parameter int unsigned NPART      = 16,
  parameter int unsigned LAT        = 1,
  parameter bit          EXPORT_IMG = 1'b0,
  localparam int unsigned PW        = $clog2(NPART)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  bcast_t                 bc_in,
  input  logic [PW-1:0]          rd_pid,
  output logic [REG_W-1:0]       rd_val,
  output logic [NPART*REG_W-1:0] img_flat
);
  bcast_t           applied;
  logic             wen;
  logic [REG_W-1:0] mem_q [NPART];
  logic [REG_W-1:0] mem_d [NPART];

  sbank_delay #(.DEPTH(LAT)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (bc_in),
    .d_out(applied)
  );

  assign wen = applied.vld && (32'(applied.pid) < NPART);

  // next state: update one half of one entry
  always_comb begin
    for (int p = 0; p < NPART; p++) mem_d[p] = mem_q[p];
    if (wen) begin
      if (applied.hi) mem_d[applied.pid[PW-1:0]][REG_W-1:VAL_W] = applied.val;
      else            mem_d[applied.pid[PW-1:0]][VAL_W-1:0]     = applied.val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPART; p++) mem_q[p] <= '0;
    end else if (wen) begin
      for (int p = 0; p < NPART; p++) mem_q[p] <= mem_d[p];
    end
  end

  assign rd_val = mem_q[rd_pid];

  // Only the designated source slice drives its image; the others drive zero
  for (genvar p = 0; p < NPART; p++) begin : g_img
    if (EXPORT_IMG) begin : g_on
      assign img_flat[p*REG_W +: REG_W] = mem_q[p];
    end else begin : g_off
      assign img_flat[p*REG_W +: REG_W] = '0;
    end
  end
endmodule

// File: rtl/sbank_commit.sv
module sbank_commit
  import sbank_pkg::*;
#(
  parameter int unsigned NPART = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spare_wr,
  input  logic [NPART*REG_W-1:0] src_flat,
  output logic [NPART*VAL_W-1:0] act_min,
  output logic [NPART*VAL_W-1:0] act_max
);
  logic                   armed_q, armed_d;
  logic                   fire;
  logic [NPART*REG_W-1:0] act_q;

  assign fire = spare_wr && armed_q;

  always_comb begin
    armed_d = armed_q;
    if (spare_wr) armed_d = !armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (fire) act_q <= src_flat;
  end

  for (genvar p = 0; p < NPART; p++) begin : g_out
    assign act_min[p*VAL_W +: VAL_W] = act_q[p*REG_W +: VAL_W];
    assign act_max[p*VAL_W +: VAL_W] = act_q[p*REG_W+VAL_W +: VAL_W];
  end

  // R5: the first spare write only arms
  p_first_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spare_wr && !armed_q |=> armed_q && $stable(act_q))
    else $error("R5 first spare write changed active rank");

  // R5: no spare write means the active rank holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !spare_wr |=> $stable(act_q))
    else $error("R5 active rank changed without commit");

  // R6: an armed spare write loads the source image and disarms
  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spare_wr && armed_q |=> !armed_q && (act_q == $past(src_flat)))
    else $error("R6 commit did not load source image");
endmodule

// File: rtl/sbank_top.sv
module sbank_top
  import sbank_pkg::*;
#(
  parameter int unsigned NSLICE   = 12,
  parameter int unsigned NPART    = 16,
  parameter int unsigned LAT_BASE = 1,
  parameter int unsigned LAT_STEP = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [23:0]            wr_addr,
  input  logic [63:0]            wr_data,
  input  logic                   rd_en,
  input  logic [23:0]            rd_addr,
  output logic [63:0]            rd_data,
  output logic                   rd_valid,
  output logic [NPART*32-1:0]    act_min,
  output logic [NPART*32-1:0]    act_max
);
  localparam int unsigned SW  = $clog2(NSLICE);
  localparam int unsigned PW  = $clog2(NPART);
  localparam int unsigned SRC = NSLICE - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  // write decode
  logic                   cfg_sel;
  logic [PID_FIELD_W-1:0] cfg_pid;
  logic                   spare_wr;
  bcast_t                 bc;

  assign cfg_sel  = wr_en && (wr_addr[ADDR_W-1:9] == '0) && (wr_addr[2:0] == 3'b000);
  assign cfg_pid  = wr_addr[7:3];
  assign spare_wr = wr_en && ((wr_addr == SPARE_A) || (wr_addr == SPARE_B));

  always_comb begin
    bc.vld = cfg_sel && (32'(cfg_pid) < NPART);
    bc.hi  = wr_addr[8];
    bc.pid = cfg_pid;
    bc.val = wr_addr[8] ? wr_data[63:32] : wr_data[31:0];
  end

  // read decode
  logic [ADDR_W-1:0] rd_ofs;
  logic [7:0]        rd_slice;
  logic [12:0]       rd_pidf;
  logic              shd_hit;

  assign rd_ofs   = rd_addr - SHADOW_BASE;
  assign rd_slice = rd_ofs[23:16];
  assign rd_pidf  = rd_ofs[15:3];
  assign shd_hit  = (rd_addr >= SHADOW_BASE) && (rd_ofs[2:0] == 3'b000)
                 && (32'(rd_pidf) < NPART) && (32'(rd_slice) < NSLICE);

  // slices
  logic [REG_W-1:0]       slice_rd [NSLICE];
  logic [NPART*REG_W-1:0] img_all  [NSLICE];
  logic [NPART*REG_W-1:0] src_img;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    sbank_slice #(
      .NPART     (NPART),
      .LAT       (LAT_BASE + s * LAT_STEP),
      .EXPORT_IMG(s == SRC)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_s),
      .bc_in   (bc),
      .rd_pid  (rd_pidf[PW-1:0]),
      .rd_val  (slice_rd[s]),
      .img_flat(img_all[s])
    );
  end

  always_comb begin
    src_img = '0;
    for (int s = 0; s < NSLICE; s++) src_img = src_img | img_all[s];
  end

  sbank_commit #(.NPART(NPART)) u_commit (
    .clk     (clk),
    .rst_n   (rst_s),
    .spare_wr(spare_wr),
    .src_flat(src_img),
    .act_min (act_min),
    .act_max (act_max)
  );

  // read return
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rd_data_q;
  logic             rd_valid_q;

  always_comb begin
    rd_mux = '0;
    if (shd_hit) rd_mux = slice_rd[rd_slice[SW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_mux;
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R9: read strobe yields a valid beat on the next edge
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en |=> rd_valid)
    else $error("R9 rd_valid missing");

  // R9: unmapped reads return zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en && !shd_hit |=> rd_data == '0)
    else $error("R9 unmapped read not zero");

  // R8: an out-of-range partition never reaches the slices
  p_cfg_drop_r8: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en && (wr_addr[ADDR_W-1:9] == '0) && (32'(wr_addr[7:3]) >= NPART) |-> !bc.vld)
    else $error("R8 out-of-range partition broadcast");

  // R4: writes to the shadow window are not broadcast
  p_shadow_ro_r4: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en && (wr_addr >= SHADOW_BASE) |-> !bc.vld && !spare_wr)
    else $error("R4 write into shadow window had effect");
endmodule

// File: tb/sim_sbank_top.sv
module sim_sbank_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en, rd_en;
  logic [23:0] wr_addr, rd_addr;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic [511:0] act_min, act_max;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  sbank_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .act_min(act_min), .act_max(act_max)
  );

  localparam logic [23:0] SPA = 24'h1B0000;
  localparam logic [23:0] SPB = 24'h1C0000;

  function automatic logic [23:0] shd(int s, int p);
    return 24'h360048 + 24'(s) * 24'h10000 + 24'(p) * 24'd8;
  endfunction
  function automatic logic [23:0] cmin(int p);
    return 24'(p) * 24'd8;
  endfunction
  function automatic logic [23:0] cmax(int p);
    return 24'h100 + 24'(p) * 24'd8;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [23:0] a, logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [23:0] a, logic [63:0] e, string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_act(int p, logic [63:0] e, string tag);
    check64(tag, {act_max[p*32 +: 32], act_min[p*32 +: 32]}, e);
  endtask

  // monitor: pop expected items as read results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected rd_valid actual=1 expected=0");
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check64(it.tag, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check64("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    for (int p = 0; p < 16; p++) chk_act(p, 64'd0, "R1 active reset");
    do_rd(shd(0, 0), 64'd0, "R1 shadow s0p0");
    do_rd(shd(11, 15), 64'd0, "R1 shadow s11p15");

    // R2 broadcast of both halves
    do_wr(cmin(2), 64'h0000_0000_0000_1234);
    do_wr(cmax(2), 64'h0000_ABCD_0000_0000);
    idle(16);
    for (int s = 0; s < 12; s++) do_rd(shd(s, 2), 64'h0000_ABCD_0000_1234, "R2 broadcast");

    // R5 no commit yet, then arm only
    chk_act(2, 64'd0, "R5 before commit");
    do_wr(SPA, 64'd0);
    idle(2);
    chk_act(2, 64'd0, "R5 armed only");

    // R6 second spare write commits
    do_wr(SPB, 64'd0);
    chk_act(2, 64'h0000_ABCD_0000_1234, "R6 commit pid2");
    chk_act(3, 64'd0, "R6 commit pid3");

    // R3 per-slice latency, write on edge k
    do_wr(cmin(5), 64'h55);
    do_rd(shd(0, 5), 64'd0,  "R3 s0 edge k+1");
    do_rd(shd(0, 5), 64'h55, "R3 s0 edge k+2");
    do_rd(shd(2, 5), 64'd0,  "R3 s2 edge k+3");
    do_rd(shd(2, 5), 64'h55, "R3 s2 edge k+4");
    do_rd(shd(11, 5), 64'd0, "R3 s11 edge k+5");
    idle(6);
    do_rd(shd(11, 5), 64'd0,  "R3 s11 edge k+12");
    do_rd(shd(11, 5), 64'h55, "R3 s11 edge k+13");
    check64("R9 rd_valid high", {63'd0, rd_valid}, 64'd1);

    // R7 early commit captures stale value
    idle(2);
    do_wr(cmin(2), 64'h9999);
    do_wr(SPB, 64'd0);
    do_wr(SPA, 64'd0);
    chk_act(2, 64'h0000_ABCD_0000_1234, "R7 stale commit");
    chk_act(5, 64'h0000_0000_0000_0055, "R6 settled pid5");
    do_rd(shd(0, 2), 64'h0000_ABCD_0000_9999, "R7 fast slice already new");
    idle(14);
    do_wr(SPA, 64'd0);
    do_wr(SPA, 64'd0);
    chk_act(2, 64'h0000_ABCD_0000_9999, "R6 commit after settle");

    // R8 out-of-range partition dropped
    do_wr(cmin(20), 64'h77);
    do_wr(cmax(20), 64'h0000_0088_0000_0000);
    idle(15);
    do_rd(shd(0, 4), 64'd0, "R8 s0p4");
    do_rd(shd(11, 4), 64'd0, "R8 s11p4");
    do_wr(SPA, 64'd0);
    do_wr(SPB, 64'd0);
    chk_act(4, 64'd0, "R8 active pid4");
    chk_act(2, 64'h0000_ABCD_0000_9999, "R8 active pid2");

    // R4 shadow window is read-only
    do_wr(shd(3, 2), 64'hDEAD_BEEF_DEAD_BEEF);
    do_wr(shd(0, 6), 64'hDEAD_BEEF_DEAD_BEEF);
    idle(15);
    do_rd(shd(3, 2), 64'h0000_ABCD_0000_9999, "R4 s3p2");
    do_rd(shd(0, 6), 64'd0, "R4 s0p6");

    // R9 unmapped reads
    do_rd(shd(0, 2) + 24'd4, 64'd0, "R9 misaligned");
    do_rd(shd(12, 0), 64'd0, "R9 slice 12");
    do_rd(shd(0, 16), 64'd0, "R9 pid 16");
    do_rd(cmin(2), 64'd0, "R9 config location");
    do_rd(SPA, 64'd0, "R9 spare location");
    idle(2);
    check64("R9 rd_valid low", {63'd0, rd_valid}, 64'd0);
    check64("R9 scoreboard drained", 64'(sb_q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule